// File: doc/BRIEF.md
# Host-EC mailbox with software interrupts

This register block links a host-side byte bus to an embedded-controller (EC) bus. It carries one byte-wide mailbox in each direction. It also keeps a 16-bit interrupt source word that the host reads as two byte registers. The EC posts software interrupts into bits 1 to 15 of that word through a write-one-to-set register. Bit 0 of the word shows that the EC-to-host mailbox holds a byte the host has not acknowledged.

Each software interrupt bit has its own host-clear enable. Where the enable is off, the host cannot clear the bit, so it behaves as a level flag that only the EC controls. Where the enable is on, a host write of 1 clears the bit, so it behaves as an edge flag that the host acknowledges. The EC clears bits of the host-to-EC mailbox by writing ones. Every host write to that mailbox raises a one-cycle EC interrupt request. The host event output is high while any source bit is set and the host has set its event enable.

Both ports write on the clock edge when their strobe is high. Read data on both ports follows the address within the same cycle.

Top module: `hostec_mbox_top`

## Requirements
- R1: After reset, both mailboxes, the interrupt source word, the host-clear mask and the host event enable are zero, and both outputs are low.
- R2: A host write to host address 0 loads the host-to-EC mailbox, which the host reads at address 0 and the EC reads at EC address 0. `ec_irq` is high for exactly the cycle that follows each such write.
- R3: An EC write to EC address 0 clears every host-to-EC mailbox bit whose write bit is 1 and leaves the rest. When a host write to host address 0 falls in the same cycle, the host data is loaded.
- R4: An EC write to EC address 1 loads the EC-to-host mailbox from `e_wdata[7:0]` and sets source bit 0. A host write to host address 1 with `h_wdata[0]=1` clears source bit 0, and one with `h_wdata[0]=0` leaves it. When both happen in the same cycle, the bit ends up set. The host reads the mailbox at address 1.
- R5: An EC write to EC address 2 sets each source bit 15..1 whose write bit is 1. Zero bits and write bit 0 have no effect. The EC reads the whole source word at EC address 2.
- R6: The host reads source bits 7..0 at host address 2 and bits 15..8 at host address 3.
- R7: The host-clear mask is written and read at EC address 3 and resets to zero. Mask bit 0 always reads 0. A host write of 1 to a source bit whose mask bit is 0 leaves it unchanged.
- R8: For a source bit 15..1 whose mask bit is 1, a host write of 1 at address 2 (bits 7..0) or address 3 (bits 15..8) clears it. A 0 bit leaves it unchanged.
- R9: If an EC set and a permitted host clear reach the same source bit in one cycle, the bit ends up set.
- R10: Host address 4 bit 0 is the host event enable. `host_event` is high exactly when that enable is 1 and the source word is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 3 | Host register address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data for `h_addr` |
| e_wr | input | 1 | EC write strobe |
| e_addr | input | 3 | EC register address |
| e_wdata | input | 16 | EC write data |
| e_rdata | output | 16 | EC read data for `e_addr` |
| host_event | output | 1 | Host event request |
| ec_irq | output | 1 | One-cycle EC interrupt request |

## Verification
The assertions check the following on every cycle:
- that `ec_irq` is tied to a host mailbox write in the previous cycle;
- that EC clear and set writes take effect one cycle later;
- that no masked software bit ever falls;
- that the host event never fires while the source word is empty.

Other behaviours show only in the bench scenarios, against its reference model:
- the byte placement of the source word in the host view;
- the write collisions between the two ports;
- the mailbox acknowledge with data 0 versus 1;
- the host event enable gating a source word that is not empty.

// File: rtl/hostec_mbox_pkg.sv
package hostec_mbox_pkg;
    // host-side register offsets
    localparam int HA_H2E  = 0;
    localparam int HA_E2H  = 1;
    localparam int HA_SRC0 = 2;   // source word bytes follow, low byte first

    // EC-side register offsets
    localparam int EA_H2E  = 0;
    localparam int EA_E2H  = 1;
    localparam int EA_SWI  = 2;
    localparam int EA_MASK = 3;

    // mask of the bits that can carry a software interrupt (bit 0 excluded)
    function automatic logic [63:0] swi_bits_of(input int width);
        logic [63:0] m;
        m = '0;
        for (int i = 1; i < width; i++) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/hostec_mbox_pair.sv
module hostec_mbox_pair #(
    parameter int MB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            h_load,
    input  logic [MB_W-1:0] h_data,
    input  logic            h_ack,
    input  logic            e_clr,
    input  logic            e_load,
    input  logic [MB_W-1:0] e_data,
    output logic [MB_W-1:0] h2e,
    output logic [MB_W-1:0] e2h,
    output logic            unread,
    output logic            irq
);
    typedef struct packed {
        logic [MB_W-1:0] h2e;
        logic [MB_W-1:0] e2h;
        logic            unread;
        logic            irq;
    } pair_t;

    pair_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = h_load;
        // host load takes priority over an EC clear in the same cycle
        if (h_load) begin
            st_d.h2e = h_data;
        end else if (e_clr) begin
            st_d.h2e = st_q.h2e & ~e_data;
        end
        if (e_load) begin
            st_d.e2h    = e_data;
            st_d.unread = 1'b1;
        end else if (h_ack) begin
            st_d.unread = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h2e    = st_q.h2e;
    assign e2h    = st_q.e2h;
    assign unread = st_q.unread;
    assign irq    = st_q.irq;
endmodule

// File: rtl/hostec_swi_word.sv
module hostec_swi_word #(
    parameter int SRC_W = 16,
    parameter int MB_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e_set,
    input  logic              e_mask_wr,
    input  logic [SRC_W-1:0]  e_data,
    input  logic [SRC_W/MB_W-1:0] h_clr_stb,
    input  logic [MB_W-1:0]   h_data,
    output logic [SRC_W-1:0]  swi,
    output logic [SRC_W-1:0]  mask
);
    import hostec_mbox_pkg::*;

    localparam int NBYTES = SRC_W / MB_W;
    localparam logic [SRC_W-1:0] SWI_BITS = SRC_W'(swi_bits_of(SRC_W));

    typedef struct packed {
        logic [SRC_W-1:0] swi;
        logic [SRC_W-1:0] mask;
    } swi_t;

    swi_t st_d, st_q;
    logic [SRC_W-1:0] clr_raw;
    logic [SRC_W-1:0] clr_ok;
    logic [SRC_W-1:0] set_req;

    // place each host byte write at its lane of the source word
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign clr_raw[k*MB_W +: MB_W] = h_clr_stb[k] ? h_data : '0;
    end

    always_comb begin
        st_d    = st_q;
        clr_ok  = clr_raw & st_q.mask;
        set_req = e_set ? (e_data & SWI_BITS) : '0;
        // a set lands after the clear, so it wins a collision
        st_d.swi = (st_q.swi & ~clr_ok) | set_req;
        if (e_mask_wr) st_d.mask = e_data & SWI_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign swi  = st_q.swi;
    assign mask = st_q.mask;
endmodule

// File: rtl/hostec_event_ctl.sv
module hostec_event_ctl #(
    parameter int SRC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             en_val,
    input  logic [SRC_W-1:0] src,
    output logic             en,
    output logic             host_event
);
    typedef struct packed {
        logic en;
    } ev_t;

    ev_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_wr) st_d.en = en_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en         = st_q.en;
    assign host_event = st_q.en && (src != '0);
endmodule

// File: rtl/hostec_mbox_top.sv
module hostec_mbox_top #(
    parameter int MB_W  = 8,
    parameter int SRC_W = 16,
    parameter int HA_W  = 3,
    parameter int EA_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             h_wr,
    input  logic [HA_W-1:0]  h_addr,
    input  logic [MB_W-1:0]  h_wdata,
    output logic [MB_W-1:0]  h_rdata,
    input  logic             e_wr,
    input  logic [EA_W-1:0]  e_addr,
    input  logic [SRC_W-1:0] e_wdata,
    output logic [SRC_W-1:0] e_rdata,
    output logic             host_event,
    output logic             ec_irq
);
    import hostec_mbox_pkg::*;

    localparam int NBYTES = SRC_W / MB_W;
    localparam int HA_CTL = HA_SRC0 + NBYTES;

    logic [MB_W-1:0]   h2e_q;
    logic [MB_W-1:0]   e2h_q;
    logic              unread;
    logic [SRC_W-1:0]  swi_q;
    logic [SRC_W-1:0]  mask_q;
    logic [SRC_W-1:0]  src_word;
    logic              ev_en;
    logic [NBYTES-1:0] h_clr_stb;

    logic h_hit_h2e, h_hit_e2h, h_hit_ctl;
    logic e_hit_h2e, e_hit_e2h, e_hit_swi, e_hit_mask;

    assign h_hit_h2e  = h_wr && (h_addr == HA_W'(HA_H2E));
    assign h_hit_e2h  = h_wr && (h_addr == HA_W'(HA_E2H));
    assign h_hit_ctl  = h_wr && (h_addr == HA_W'(HA_CTL));
    assign e_hit_h2e  = e_wr && (e_addr == EA_W'(EA_H2E));
    assign e_hit_e2h  = e_wr && (e_addr == EA_W'(EA_E2H));
    assign e_hit_swi  = e_wr && (e_addr == EA_W'(EA_SWI));
    assign e_hit_mask = e_wr && (e_addr == EA_W'(EA_MASK));

    for (genvar k = 0; k < NBYTES; k++) begin : g_stb
        assign h_clr_stb[k] = h_wr && (h_addr == HA_W'(HA_SRC0 + k));
    end

    hostec_mbox_pair #(.MB_W(MB_W)) pair_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .h_load (h_hit_h2e),
        .h_data (h_wdata),
        .h_ack  (h_hit_e2h && h_wdata[0]),
        .e_clr  (e_hit_h2e),
        .e_load (e_hit_e2h),
        .e_data (e_wdata[MB_W-1:0]),
        .h2e    (h2e_q),
        .e2h    (e2h_q),
        .unread (unread),
        .irq    (ec_irq)
    );

    hostec_swi_word #(.SRC_W(SRC_W), .MB_W(MB_W)) swi_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .e_set     (e_hit_swi),
        .e_mask_wr (e_hit_mask),
        .e_data    (e_wdata),
        .h_clr_stb (h_clr_stb),
        .h_data    (h_wdata),
        .swi       (swi_q),
        .mask      (mask_q)
    );

    assign src_word = swi_q | SRC_W'(unread);

    hostec_event_ctl #(.SRC_W(SRC_W)) ev_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_wr      (h_hit_ctl),
        .en_val     (h_wdata[0]),
        .src        (src_word),
        .en         (ev_en),
        .host_event (host_event)
    );

    always_comb begin
        h_rdata = '0;
        if (h_addr == HA_W'(HA_H2E))      h_rdata = h2e_q;
        else if (h_addr == HA_W'(HA_E2H)) h_rdata = e2h_q;
        else if (h_addr == HA_W'(HA_CTL)) h_rdata = MB_W'(ev_en);
        for (int k = 0; k < NBYTES; k++) begin
            if (h_addr == HA_W'(HA_SRC0 + k)) h_rdata = src_word[k*MB_W +: MB_W];
        end
    end

    always_comb begin
        e_rdata = '0;
        if (e_addr == EA_W'(EA_H2E))       e_rdata = SRC_W'(h2e_q);
        else if (e_addr == EA_W'(EA_E2H))  e_rdata = SRC_W'(e2h_q);
        else if (e_addr == EA_W'(EA_SWI))  e_rdata = src_word;
        else if (e_addr == EA_W'(EA_MASK)) e_rdata = mask_q;
    end
endmodule

// File: rtl/hostec_mbox_chk.sv
module hostec_mbox_chk #(
    parameter int MB_W  = 8,
    parameter int SRC_W = 16,
    parameter int HA_W  = 3,
    parameter int EA_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             h_wr,
    input logic [HA_W-1:0]  h_addr,
    input logic             e_wr,
    input logic [EA_W-1:0]  e_addr,
    input logic [SRC_W-1:0] e_wdata,
    input logic             host_event,
    input logic             ec_irq,
    input logic [MB_W-1:0]  h2e,
    input logic             unread,
    input logic [SRC_W-1:0] src,
    input logic [SRC_W-1:0] mask
);
    import hostec_mbox_pkg::*;

    localparam logic [SRC_W-1:0] SWI_BITS = SRC_W'(swi_bits_of(SRC_W));

    // R2
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ec_irq |-> $past(h_wr && (h_addr == HA_W'(HA_H2E))));

    // R2
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && (h_addr == HA_W'(HA_H2E))) |=> ec_irq);

    // R3
    h2e_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_wr && (e_addr == EA_W'(EA_H2E)) && !(h_wr && (h_addr == HA_W'(HA_H2E))))
        |=> ((h2e & $past(e_wdata[MB_W-1:0])) == '0));

    // R4
    unread_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_wr && (e_addr == EA_W'(EA_E2H))) |=> unread);

    // R9
    swi_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_wr && (e_addr == EA_W'(EA_SWI)))
        |=> ((src & $past(e_wdata) & SWI_BITS) == ($past(e_wdata) & SWI_BITS)));

    // R7
    swi_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(src) & ~src & ~$past(mask) & SWI_BITS) == '0));

    // R10
    event_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_event |-> (src != '0));
endmodule

bind hostec_mbox_top hostec_mbox_chk #(
    .MB_W(MB_W), .SRC_W(SRC_W), .HA_W(HA_W), .EA_W(EA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_wr       (h_wr),
    .h_addr     (h_addr),
    .e_wr       (e_wr),
    .e_addr     (e_addr),
    .e_wdata    (e_wdata),
    .host_event (host_event),
    .ec_irq     (ec_irq),
    .h2e        (h2e_q),
    .unread     (unread),
    .src        (src_word),
    .mask       (mask_q)
);

// File: tb/hostec_mbox_tb.sv
module hostec_mbox_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr = 1'b0;
    logic [2:0]  h_addr = '0;
    logic [7:0]  h_wdata = '0;
    logic [7:0]  h_rdata;
    logic        e_wr = 1'b0;
    logic [2:0]  e_addr = '0;
    logic [15:0] e_wdata = '0;
    logic [15:0] e_rdata;
    logic        host_event;
    logic        ec_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0]  m_h2e = '0, m_e2h = '0;
    logic        m_unread = 1'b0, m_en = 1'b0, m_irq = 1'b0;
    logic [15:0] m_swi = '0, m_mask = '0;

    always #4 clk = ~clk;

    hostec_mbox_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .e_wr(e_wr), .e_addr(e_addr), .e_wdata(e_wdata), .e_rdata(e_rdata),
        .host_event(host_event), .ec_irq(ec_irq)
    );

    function automatic logic [15:0] m_src();
        return m_swi | {15'b0, m_unread};
    endfunction

    function automatic logic [7:0] m_hrd(input logic [2:0] a);
        case (a)
            3'd0: return m_h2e;
            3'd1: return m_e2h;
            3'd2: return m_src()[7:0];
            3'd3: return m_src()[15:8];
            3'd4: return {7'b0, m_en};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] m_erd(input logic [2:0] a);
        case (a)
            3'd0: return {8'h00, m_h2e};
            3'd1: return {8'h00, m_e2h};
            3'd2: return m_src();
            3'd3: return m_mask;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_step();
        logic [15:0] clr, setv;
        m_irq = h_wr && (h_addr == 3'd0);
        if (h_wr && h_addr == 3'd0) m_h2e = h_wdata;
        else if (e_wr && e_addr == 3'd0) m_h2e = m_h2e & ~e_wdata[7:0];
        if (e_wr && e_addr == 3'd1) begin
            m_e2h = e_wdata[7:0];
            m_unread = 1'b1;
        end else if (h_wr && h_addr == 3'd1 && h_wdata[0]) begin
            m_unread = 1'b0;
        end
        clr = 16'h0;
        if (h_wr && h_addr == 3'd2) clr = {8'h00, h_wdata};
        if (h_wr && h_addr == 3'd3) clr = {h_wdata, 8'h00};
        clr = clr & m_mask;
        setv = (e_wr && e_addr == 3'd2) ? (e_wdata & 16'hFFFE) : 16'h0;
        m_swi = (m_swi & ~clr) | setv;
        if (e_wr && e_addr == 3'd3) m_mask = e_wdata & 16'hFFFE;
        if (h_wr && h_addr == 3'd4) m_en = h_wdata[0];
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 ec_irq", {15'b0, ec_irq}, {15'b0, m_irq});
        chk("R10 host_event", {15'b0, host_event}, {15'b0, m_en && (m_src() != 16'h0)});
        chk("R6 h_rdata", {8'h00, h_rdata}, {8'h00, m_hrd(h_addr)});
        chk("R5 e_rdata", e_rdata, m_erd(e_addr));
    endtask

    // one clock: drive after a falling edge, model at the rising edge, compare at the next falling edge
    task automatic cyc(input logic hw, input logic [2:0] ha, input logic [7:0] hd,
                       input logic ew, input logic [2:0] ea, input logic [15:0] ed);
        h_wr = hw; h_addr = ha; h_wdata = hd;
        e_wr = ew; e_addr = ea; e_wdata = ed;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic rd(input logic [2:0] ha, input logic [2:0] ea);
        cyc(1'b0, ha, 8'h00, 1'b0, ea, 16'h0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, 3'd0);
        chk("R1 h2e host", {8'h00, h_rdata}, 16'h0000);
        chk("R1 h2e ec", e_rdata, 16'h0000);
        chk("R1 outputs", {14'b0, host_event, ec_irq}, 16'h0000);
        rd(3'd3, 3'd3);
        chk("R1 src high", {8'h00, h_rdata}, 16'h0000);
        chk("R7 mask reset", e_rdata, 16'h0000);

        // R2 host mailbox load and irq pulse
        cyc(1'b1, 3'd0, 8'hA5, 1'b0, 3'd0, 16'h0);
        chk("R2 irq high", {15'b0, ec_irq}, 16'h0001);
        chk("R2 h2e host view", {8'h00, h_rdata}, 16'h00A5);
        chk("R2 h2e ec view", e_rdata, 16'h00A5);
        rd(3'd0, 3'd0);
        chk("R2 irq one cycle", {15'b0, ec_irq}, 16'h0000);

        // R3 EC write-one-to-clear, then collision
        cyc(1'b0, 3'd0, 8'h00, 1'b1, 3'd0, 16'h000F);
        chk("R3 partial clear", e_rdata, 16'h00A0);
        cyc(1'b1, 3'd0, 8'h3C, 1'b1, 3'd0, 16'h00FF);
        chk("R3 host load wins", e_rdata, 16'h003C);

        // R4 EC-to-host mailbox and unread flag
        cyc(1'b0, 3'd1, 8'h00, 1'b1, 3'd1, 16'h005A);
        chk("R4 e2h data", {8'h00, h_rdata}, 16'h005A);
        rd(3'd2, 3'd2);
        chk("R4 unread set", {8'h00, h_rdata}, 16'h0001);
        chk("R10 enable off", {15'b0, host_event}, 16'h0000);
        cyc(1'b1, 3'd4, 8'h01, 1'b0, 3'd2, 16'h0);
        chk("R10 event on", {15'b0, host_event}, 16'h0001);
        cyc(1'b1, 3'd1, 8'h00, 1'b0, 3'd2, 16'h0);
        chk("R4 ack with 0 keeps", e_rdata, 16'h0001);
        cyc(1'b1, 3'd1, 8'h01, 1'b0, 3'd2, 16'h0);
        chk("R4 ack with 1 clears", e_rdata, 16'h0000);
        chk("R10 event off when empty", {15'b0, host_event}, 16'h0000);
        cyc(1'b1, 3'd1, 8'h01, 1'b1, 3'd1, 16'h0011);
        rd(3'd2, 3'd2);
        chk("R4 set beats ack", e_rdata, 16'h0001);
        cyc(1'b1, 3'd1, 8'h01, 1'b0, 3'd2, 16'h0);

        // R5 / R6 software interrupt set
        cyc(1'b0, 3'd2, 8'h00, 1'b1, 3'd2, 16'h8003);
        chk("R5 set bits, bit0 ignored", e_rdata, 16'h8002);
        chk("R6 low byte", {8'h00, h_rdata}, 16'h0002);
        rd(3'd3, 3'd2);
        chk("R6 high byte", {8'h00, h_rdata}, 16'h0080);
        cyc(1'b0, 3'd2, 8'h00, 1'b1, 3'd2, 16'h0000);
        chk("R5 zero write no effect", e_rdata, 16'h8002);

        // R7 host clear blocked by zero mask
        cyc(1'b1, 3'd3, 8'hFF, 1'b0, 3'd2, 16'h0);
        cyc(1'b1, 3'd2, 8'hFF, 1'b0, 3'd2, 16'h0);
        chk("R7 blocked clear", e_rdata, 16'h8002);
        cyc(1'b0, 3'd0, 8'h00, 1'b1, 3'd3, 16'hFFFF);
        chk("R7 mask bit0 reads 0", e_rdata, 16'hFFFE);

        // R8 host clear allowed by mask
        cyc(1'b1, 3'd3, 8'h80, 1'b0, 3'd2, 16'h0);
        chk("R8 clear bit 15", e_rdata, 16'h0002);
        cyc(1'b1, 3'd2, 8'h00, 1'b0, 3'd2, 16'h0);
        chk("R8 zero leaves", e_rdata, 16'h0002);
        cyc(1'b1, 3'd2, 8'h02, 1'b0, 3'd2, 16'h0);
        chk("R8 clear bit 1", e_rdata, 16'h0000);

        // R9 set and permitted clear in one cycle
        cyc(1'b0, 3'd0, 8'h00, 1'b1, 3'd3, 16'h0004);
        cyc(1'b0, 3'd0, 8'h00, 1'b1, 3'd2, 16'h0004);
        cyc(1'b1, 3'd2, 8'h04, 1'b1, 3'd2, 16'h0004);
        chk("R9 set wins", e_rdata, 16'h0004);
        cyc(1'b1, 3'd2, 8'h04, 1'b0, 3'd2, 16'h0);
        chk("R9 later clear", e_rdata, 16'h0000);

        // R10 enable gates a non-empty word
        cyc(1'b0, 3'd4, 8'h00, 1'b1, 3'd2, 16'h0100);
        chk("R10 event with source", {15'b0, host_event}, 16'h0001);
        cyc(1'b1, 3'd4, 8'h00, 1'b0, 3'd2, 16'h0);
        chk("R10 disabled", {15'b0, host_event}, 16'h0000);
        chk("R10 enable reads 0", {8'h00, h_rdata}, 16'h0000);

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            cyc(1'($urandom_range(0, 1)), 3'($urandom_range(0, 5)), 8'($urandom),
                1'($urandom_range(0, 1)), 3'($urandom_range(0, 4)), 16'($urandom));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule